// File: doc/BRIEF.md
# Serial Receiver with Latched Line Status

This block turns an asynchronous serial line back into characters. It shares its character format settings with the matching transmitter: word length, parity enable and parity sense, and the stop-bit count. Framing is timed by a sixteen-times-oversampling tick that comes from outside the block. The line input is taken to be synchronous to the clock already.

Each finished character goes into a receive queue together with its own parity, framing and break flags. A status byte reports:

- whether data is waiting;
- error conditions, which stay latched until the status byte is read;
- two transmitter state bits, which are passed straight through.

An interrupt request is raised while any latched error is present and the interrupt is enabled. The queue either holds many characters or acts as a single holding register, depending on a mode input.

Top module: `uart_rx_status`

## Requirements
- R1: A low line seen on a tick starts a frame. The start is confirmed only if the line is still low 8 ticks later; otherwise the receiver returns to idle. Each later bit is sampled every 16 ticks after that point. Data arrives LSB first. `line_ctrl[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length read as zero on `rx_data`.
- R2: When `line_ctrl[3]`=1, one parity bit follows the data. `line_ctrl[4]`=1 selects even parity and 0 selects odd parity. A mismatch marks that character with a parity error, which shows as `status[2]`.
- R3: Only the first stop bit is checked, and `line_ctrl[2]` (the stop-bit count) has no effect on reception. A stop bit sampled low marks a framing error, which shows as `status[3]`.
- R4: A character whose start, data, parity and stop samples are all low is marked as a break, which shows as `status[4]`. It is also marked as a framing error.
- R5: With `fifo_en`=1, up to 16 characters are held in arrival order, each with its own flags. `rx_data` shows the oldest character, and a pulse on `rd_data` removes it. The error bits latch from the flags of the oldest character.
- R6: With `fifo_en`=1, a character that completes while 16 are held, with no removal in the same cycle, is discarded and sets `status[1]`.
- R7: With `fifo_en`=0, one character is held. A new character replaces an unread one and sets `status[1]`. The mode may only be changed while the queue is empty.
- R8: `status[0]` is 1 exactly while at least one character is held.
- R9: `status[4:1]` set from overrun events and from the flags of the oldest held character. Once set, they stay set even after that character is removed. A pulse on `rd_status` clears all four bits in the next cycle.
- R10: `irq` is high exactly when `irq_en` is 1 and any of `status[4:1]` is 1.
- R11: `status[5]` follows `tx_hold_empty`, `status[6]` follows `tx_empty`, and `status[7]` is 0.
- R12: After reset no character is held, `status[4:0]`=0, `rx_data`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| tick_16x | input | 1 | One-cycle pulse at sixteen times the bit rate |
| line_ctrl | input | 8 | Character format: [1:0] length, [2] stop count, [3] parity enable, [4] even parity |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding register |
| rd_data | input | 1 | Removes the oldest character |
| rd_status | input | 1 | Status read; clears the latched error bits |
| irq_en | input | 1 | Line-status interrupt enable |
| tx_hold_empty | input | 1 | Transmitter holding state, reported on status[5] |
| tx_empty | input | 1 | Transmitter idle state, reported on status[6] |
| rx_data | output | 8 | Oldest held character, 0 when none |
| status | output | 8 | Line status byte |
| irq | output | 1 | Line-status interrupt request |

## Verification
A bit-sampling phase that drifts by even one tick shows up within one character as wrong data, or as a spurious framing error at the stop sample. A wrong queue pointer or count shows up on the next removal as an out-of-order `rx_data` or a wrong `status[0]`. A flag that is stored against the wrong entry, or cleared too early, becomes visible on `status[4:1]` and `irq` in the cycle after the affected character reaches the head of the queue. Because the bench compares every output on every clock, each of these faults is reported in the cycle where it first appears.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic       brk;
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_char_t;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx,
   input  logic       tick,
   input  logic [1:0] wlen,
   input  logic       par_en,
   input  logic       par_even,
   output logic       done,
   output rx_char_t   chr
);

   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   rx_state_t     st;
   logic [CW-1:0] cnt;
   logic [2:0]    idx;
   logic [2:0]    last_idx;
   logic [7:0]    sh;
   logic          all_low;
   logic          perr_q;

   assign last_idx = {1'b0, wlen} + 3'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         all_low <= 1'b0;
         perr_q  <= 1'b0;
         done    <= 1'b0;
         chr     <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (!rx) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == HALF) begin
                     cnt <= '0;
                     if (!rx) begin
                        st      <= RX_DATA;
                        idx     <= '0;
                        sh      <= '0;
                        all_low <= 1'b1;
                        perr_q  <= 1'b0;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     sh[idx] <= rx;
                     all_low <= all_low & ~rx;
                     if (idx == last_idx) st <= par_en ? RX_PARITY : RX_STOP;
                     else                 idx <= idx + 3'd1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_PARITY: begin
                  if (cnt == LAST) begin
                     cnt     <= '0;
                     perr_q  <= ((^sh) ^ rx) == par_even;
                     all_low <= all_low & ~rx;
                     st      <= RX_STOP;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt      <= '0;
                     done     <= 1'b1;
                     chr.data <= sh;
                     chr.perr <= par_en & perr_q;
                     chr.ferr <= ~rx;
                     chr.brk  <= all_low & ~rx;
                     st       <= RX_IDLE;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fifo_en,
   input  logic                     push,
   input  rx_char_t                 din,
   input  logic                     pop_req,
   output rx_char_t                 dout,
   output logic                     ovr_evt,
   output logic [$clog2(DEPTH):0]   fill
);

   localparam int AW   = $clog2(DEPTH);
   localparam int CNTW = AW + 1;
   localparam logic [CNTW-1:0] FULLN = CNTW'(DEPTH);

   rx_char_t      mem [DEPTH];
   logic [AW-1:0] rp, wp;
   logic          cap_full, pop, accept, overwrite;

   assign cap_full  = fifo_en ? (fill == FULLN) : (fill != '0);
   assign pop       = pop_req && (fill != '0);
   assign accept    = push && (!cap_full || pop);
   assign overwrite = push && cap_full && !pop && !fifo_en;
   assign ovr_evt   = push && cap_full && !pop;
   assign dout      = (fill != '0) ? mem[rp] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp   <= '0;
         wp   <= '0;
         fill <= '0;
      end else begin
         if (accept) wp <= wp + AW'(1);
         if (pop)    rp <= rp + AW'(1);
         fill <= fill + CNTW'(accept) - CNTW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (accept)         mem[wp] <= din;
      else if (overwrite) mem[rp] <= din;
   end

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       head_valid,
   input  logic [2:0] head_flags,
   input  logic       ovr_evt,
   input  logic       rd_status,
   input  logic       tx_hold_empty,
   input  logic       tx_empty,
   input  logic       irq_en,
   output logic [7:0] status,
   output logic       irq
);

   logic [3:0] err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         err <= '0;
      else if (rd_status) err <= '0;
      else                err <= err | {head_flags & {3{head_valid}}, ovr_evt};
   end

   assign status = {1'b0, tx_empty, tx_hold_empty, err, head_valid};
   assign irq    = irq_en & (|err);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int OVS   = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_in,
   input  logic       tick_16x,
   input  logic [7:0] line_ctrl,
   input  logic       fifo_en,
   input  logic       rd_data,
   input  logic       rd_status,
   input  logic       irq_en,
   input  logic       tx_hold_empty,
   input  logic       tx_empty,
   output logic [7:0] rx_data,
   output logic [7:0] status,
   output logic       irq
);

   localparam int FW = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
   endgenerate

   logic          done;
   rx_char_t      new_chr, head;
   logic          ovr_evt;
   logic [FW-1:0] fill_level;
   logic          head_valid;
   logic          ctrl_unused;

   assign ctrl_unused = ^{line_ctrl[7:5], line_ctrl[2]};

   uart_rx_deser #(.OVS(OVS)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx       (rx_in),
      .tick     (tick_16x),
      .wlen     (line_ctrl[1:0]),
      .par_en   (line_ctrl[3]),
      .par_even (line_ctrl[4]),
      .done     (done),
      .chr      (new_chr)
   );

   uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .push    (done),
      .din     (new_chr),
      .pop_req (rd_data),
      .dout    (head),
      .ovr_evt (ovr_evt),
      .fill    (fill_level)
   );

   assign head_valid = (fill_level != '0);
   assign rx_data    = head.data;

   uart_rx_lsr u_lsr (
      .clk           (clk),
      .rst_n         (rst_n),
      .head_valid    (head_valid),
      .head_flags    ({head.brk, head.ferr, head.perr}),
      .ovr_evt       (ovr_evt),
      .rd_status     (rd_status),
      .tx_hold_empty (tx_hold_empty),
      .tx_empty      (tx_empty),
      .irq_en        (irq_en),
      .status        (status),
      .irq           (irq)
   );

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
   parameter int DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rd_status,
   input logic                   irq_en,
   input logic                   fifo_en,
   input logic [7:0]             status,
   input logic                   irq,
   input logic [$clog2(DEPTH):0] fill
);

   // R9: latched error bits never drop without a status read
   a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_status |=> ((status[4:1] & $past(status[4:1])) == $past(status[4:1])));

   // R9: a status read leaves the error bits clear in the next cycle
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status |=> (status[4:1] == 4'b0000));

   // R10: no request while the interrupt is disabled
   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   // R5: the queue never holds more than its depth
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= ($clog2(DEPTH) + 1)'(DEPTH));

   // R6: overrun in queue mode only rises when the queue was full
   a_r6_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status[1]) && $past(fifo_en)) |-> ($past(fill) == ($clog2(DEPTH) + 1)'(DEPTH)));

   // R7: single-register mode never holds more than one character
   a_r7_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en) && $past(fill <= 1)) |-> (fill <= 1));

endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_status (rd_status),
   .irq_en    (irq_en),
   .fifo_en   (fifo_en),
   .status    (status),
   .irq       (irq),
   .fill      (fill_level)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       tick_16x = 1'b0;
   logic [7:0] line_ctrl = 8'h03;
   logic       fifo_en = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic       irq_en = 1'b0;
   logic       tx_hold_empty = 1'b1;
   logic       tx_empty = 1'b1;
   logic [7:0] rx_data;
   logic [7:0] status;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   uart_rx_status u_uart_rx_status (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick_16x(tick_16x),
      .line_ctrl(line_ctrl), .fifo_en(fifo_en), .rd_data(rd_data),
      .rd_status(rd_status), .irq_en(irq_en), .tx_hold_empty(tx_hold_empty),
      .tx_empty(tx_empty), .rx_data(rx_data), .status(status), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) tick_16x <= 1'b0;
      else        tick_16x <= ~tick_16x;
   end

   // behavioural reference model: {brk, ferr, perr, data} per entry
   logic [10:0] mq[$];
   logic [3:0]  m_err = 4'b0;
   bit          m_act = 1'b0;
   int          m_t = 0;
   logic [7:0]  m_bits = 8'h00;
   bit          m_low = 1'b0;
   bit          m_par = 1'b0;
   bit          m_pend = 1'b0;
   logic [10:0] m_char = 11'h0;

   always @(posedge clk) begin : model
      int          sz, j, nb;
      bit          full_o, pop_e, evt, pen, pe;
      logic [10:0] hd;
      if (!rst_n) begin
         mq.delete();
         m_err  = 4'b0;
         m_act  = 1'b0;
         m_t    = 0;
         m_pend = 1'b0;
      end else begin
         sz     = mq.size();
         full_o = fifo_en ? (sz == 16) : (sz != 0);
         pop_e  = rd_data && (sz > 0);
         evt    = m_pend && full_o && !pop_e;
         hd     = (sz > 0) ? mq[0] : 11'h0;
         if (rd_status) m_err = 4'b0;
         else           m_err = m_err | {hd[10], hd[9], hd[8], evt};
         if (pop_e) void'(mq.pop_front());
         if (m_pend) begin
            if (!full_o || pop_e) mq.push_back(m_char);
            else if (!fifo_en)    mq[0] = m_char;
            m_pend = 1'b0;
         end
         if (tick_16x) begin
            if (!m_act) begin
               if (!rx_in) begin
                  m_act = 1'b1;
                  m_t   = 0;
               end
            end else begin
               m_t++;
               if (m_t == 8) begin
                  if (rx_in) m_act = 1'b0;
                  else begin
                     m_bits = 8'h00;
                     m_low  = 1'b1;
                     m_par  = 1'b0;
                  end
               end else if (m_t > 8 && ((m_t - 8) % 16) == 0) begin
                  j   = (m_t - 8) / 16;
                  nb  = int'(line_ctrl[1:0]) + 5;
                  pen = line_ctrl[3];
                  if (j <= nb) begin
                     m_bits[j-1] = rx_in;
                     if (rx_in) m_low = 1'b0;
                  end else if (pen && j == nb + 1) begin
                     m_par = rx_in;
                     if (rx_in) m_low = 1'b0;
                  end else begin
                     pe     = pen && (((^m_bits) ^ m_par) == line_ctrl[4]);
                     m_char = {m_low && !rx_in, !rx_in, pe, m_bits};
                     m_pend = 1'b1;
                     m_act  = 1'b0;
                  end
               end
            end
         end
      end
   end

   // every-clock comparison against the model
   always @(posedge clk) begin
      logic [7:0] es;
      logic [7:0] ed;
      #1;
      es = {1'b0, tx_empty, tx_hold_empty, m_err, (mq.size() != 0)};
      ed = (mq.size() != 0) ? mq[0][7:0] : 8'h00;
      chk(status[0] == es[0], "R8 data ready", status[0], es[0]);
      chk(status[4:1] == es[4:1], "R9 latched errors", status[4:1], es[4:1]);
      chk(status[7:5] == es[7:5], "R11 transmitter bits", status[7:5], es[7:5]);
      chk(irq == (irq_en && (|m_err)), "R10 interrupt", irq, irq_en && (|m_err));
      chk(rx_data == ed, "R5 head data", rx_data, ed);
   end

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit pbit, input bit stopv);
      @(negedge clk);
      rx_in = 1'b0;
      clks(32);
      for (int i = 0; i < nb; i++) begin
         rx_in = d[i];
         clks(32);
      end
      if (pen) begin
         rx_in = pbit;
         clks(32);
      end
      if (stopv) begin
         rx_in = 1'b1;
         clks(64);
      end else begin
         rx_in = 1'b0;
         clks(24);
         rx_in = 1'b1;
         clks(64);
      end
   endtask

   task automatic pop_one();
      @(negedge clk);
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
      clks(2);
   endtask

   task automatic read_status();
      @(negedge clk);
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
      clks(2);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      clks(5);
      rst_n = 1'b1;
      clks(2);
      chk(status == 8'h60, "R12 reset status", status, 8'h60);
      chk(rx_data == 8'h00, "R12 reset data", rx_data, 8'h00);
      chk(irq == 1'b0, "R12 reset irq", irq, 1'b0);

      // R1: 8-bit character, single register mode
      line_ctrl = 8'h03;
      send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'hA5, "R1 8-bit data", rx_data, 8'hA5);
      chk(status[4:0] == 5'b00001, "R1 clean status", status[4:0], 5'b00001);
      pop_one();
      chk(status[0] == 1'b0, "R8 empty after pop", status[0], 1'b0);

      // R1: 5-bit character, upper bits zero
      line_ctrl = 8'h00;
      send(8'hF5, 5, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'h15, "R1 5-bit data", rx_data, 8'h15);
      pop_one();

      // R2: odd parity correct, then even parity correct and wrong
      line_ctrl = 8'h0B;
      send(8'h03, 8, 1'b1, 1'b1, 1'b1);
      chk(status[2] == 1'b0, "R2 odd parity good", status[2], 1'b0);
      pop_one();
      line_ctrl = 8'h1B;
      irq_en = 1'b1;
      send(8'h03, 8, 1'b1, 1'b0, 1'b1);
      chk(status[2] == 1'b0, "R2 even parity good", status[2], 1'b0);
      pop_one();
      send(8'h03, 8, 1'b1, 1'b1, 1'b1);
      chk(status[2] == 1'b1, "R2 even parity error", status[2], 1'b1);
      chk(irq == 1'b1, "R10 irq on error", irq, 1'b1);
      pop_one();
      chk(status[2] == 1'b1, "R9 kept after pop", status[2], 1'b1);
      read_status();
      chk(status[4:1] == 4'b0000, "R9 cleared by read", status[4:1], 4'b0000);
      chk(irq == 1'b0, "R10 irq drops", irq, 1'b0);

      // R3: two stop bits configured, only the first is checked
      line_ctrl = 8'h07;
      send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
      chk(status[3] == 1'b0, "R3 stop config ignored", status[3], 1'b0);
      pop_one();
      send(8'h5A, 8, 1'b0, 1'b0, 1'b0);
      chk(status[4:3] == 2'b01, "R3 framing error", status[4:3], 2'b01);
      chk(rx_data == 8'h5A, "R3 data kept", rx_data, 8'h5A);
      pop_one();
      read_status();

      // R4: all-low frame
      line_ctrl = 8'h03;
      send(8'h00, 8, 1'b0, 1'b0, 1'b0);
      chk(status[4:3] == 2'b11, "R4 break and framing", status[4:3], 2'b11);
      pop_one();
      read_status();

      // R5/R6: queue mode fill beyond depth
      fifo_en = 1'b1;
      for (int i = 0; i < 17; i++) send(8'(i * 7 + 3), 8, 1'b0, 1'b0, 1'b1);
      chk(status[1] == 1'b1, "R6 overrun on full", status[1], 1'b1);
      for (int i = 0; i < 16; i++) begin
         chk(rx_data == 8'(i * 7 + 3), "R5 order", rx_data, 8'(i * 7 + 3));
         pop_one();
      end
      chk(status[0] == 1'b0, "R6 extra discarded", status[0], 1'b0);
      read_status();

      // R5: flags travel with each entry
      line_ctrl = 8'h1B;
      send(8'h01, 8, 1'b1, 1'b1, 1'b1);
      send(8'h01, 8, 1'b1, 1'b0, 1'b1);
      chk(status[2] == 1'b0, "R5 good head", status[2], 1'b0);
      pop_one();
      chk(status[2] == 1'b1, "R5 bad head", status[2], 1'b1);
      pop_one();
      irq_en = 1'b0;
      clks(1);
      chk(irq == 1'b0, "R10 disabled", irq, 1'b0);
      read_status();

      // R7: single register overwrite
      fifo_en = 1'b0;
      line_ctrl = 8'h03;
      send(8'h11, 8, 1'b0, 1'b0, 1'b1);
      send(8'h22, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'h22, "R7 newest kept", rx_data, 8'h22);
      chk(status[1] == 1'b1, "R7 overrun", status[1], 1'b1);
      pop_one();
      read_status();

      // R11: transmitter state pass-through
      tx_hold_empty = 1'b0;
      tx_empty = 1'b1;
      clks(1);
      chk(status[7:5] == 3'b010, "R11 tx bits", status[7:5], 3'b010);

      clks(4);
      finish_run();
   end

endmodule